// File: doc/BRIEF.md
# I2C Slave Address-Match Responder

This block is the target half of a two-wire serial controller. It watches the clock and data lines and compares each 7-bit address with a programmable own-address register. When the address matches, it acknowledges and raises a match event. After that it moves bytes between the bus and a software-facing byte port. Software paces every byte. A received byte, which includes the address byte with its read/write bit, is held and flagged until software clears its receive flag. A byte to be sent is supplied with a transmit command. Until software responds, the block holds the clock line low.

Two mutually exclusive enable bits select target or controller operation. Writing the target enable always clears the controller enable. Events are collected in a sticky status vector with write-one-to-clear semantics. A stop condition ends an addressed transaction. So does a not-acknowledge from the controller after a transmitted byte. A repeated start begins a new address comparison.

Top module: `i2c_addr_responder`

## Requirements
- R1: After reset both line pull-downs are released, all status bits are 0, both enables are 0 and the own address is 0.
- R2: A mode write with the target bit set enables the target and clears the controller enable even if the controller bit is also set. A mode write with only the controller bit set enables the controller and disables the target.
- R3: When bits 7:1 of the first byte after a start equal the own address, the block drives SDA low during the ninth clock. It also sets status bit 4 (match) and bit 2 (receive done), and presents the whole address byte on `rx_data`, where bit 0 is 1 for read and 0 for write.
- R4: When the address does not match, the block gives no acknowledge, sets no status bit and leaves both lines released until the next start.
- R5: In a write transaction each data byte is shifted in MSB first and appears on `rx_data`. Receive done (status bit 2) is set and the byte is acknowledged without software action.
- R6: After any received byte, SCL is held low in the low phase of the acknowledge clock while receive done is set. It is released once software clears that bit.
- R7: In a read transaction SCL is held low before each byte until a transmit command has supplied the byte. The byte is then driven MSB first, and SDA changes only while SCL is low.
- R8: A controller acknowledge after a transmitted byte sets status bit 0. A not-acknowledge sets status bit 1, releases SDA and ends the read.
- R9: A stop condition after an addressed transaction sets status bit 3 and returns the block to idle.
- R10: A repeated start before a stop restarts address comparison, so an addressed transfer can follow a missed one in the same bus session.
- R11: While the target is disabled the block ignores the bus: no acknowledge, no status bit, no line pulled low.
- R12: Status bits are sticky. A 1 in `irq_clr` clears the matching bit on the next clock. An event in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| mode_wr | input | 1 | Load the enable bits |
| mode_slave | input | 1 | Requested target enable |
| mode_master | input | 1 | Requested controller enable |
| addr_wr | input | 1 | Load the own address |
| addr_in | input | 7 | New own address |
| slave_en | output | 1 | Target enable state |
| master_en | output | 1 | Controller enable state |
| tx_go | input | 1 | Transmit command, supplies `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| irq_clr | input | 5 | Write-one-to-clear status mask |
| irq_stat | output | 5 | Status: 0 tx ack, 1 tx nak, 2 rx done, 3 stop, 4 match |
| rx_data | output | 8 | Last received byte (address or data) |

## Verification
The embedded properties check several rules on every cycle. The stretch pull-down only ever starts while SCL is already low, and the SDA pull-down only begins in an SCL low phase. A disabled target drives nothing. Status bits hold until cleared, a match always comes with receive done, and a target-enable write always wins over the controller bit. The data path can only be shown by the bench's transactions, played against an open-drain controller model and a software agent with random latency. Those transactions cover address compare and acknowledge, byte order both ways, stretching that lasts exactly as long as software delays, acknowledge and not-acknowledge classification, stop reporting and repeated-start recovery.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int STAT_W = 5;

  // status vector bit positions
  localparam int ST_TXACK  = 0;
  localparam int ST_TXNAK  = 1;
  localparam int ST_RXDONE = 2;
  localparam int ST_STOP   = 3;
  localparam int ST_MATCH  = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_IGNORE,
    S_ACK_PEND,
    S_ACK_DRV,
    S_WR_BIT,
    S_RD_WAIT,
    S_RD_SETUP,
    S_RD_BIT,
    S_RD_ACK,
    S_RD_ACKED
  } resp_state_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_d_q    <= scl_s;
      sda_d_q    <= sda_s;
    end
  end

  assign scl_s     = scl_sync_q[SYNC_STAGES-1];
  assign sda_s     = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  // data edges while the clock stays high mark start and stop
  assign start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;
endmodule

// File: rtl/i2c_resp_mode.sv
module i2c_resp_mode
  import i2c_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_slave,
  input  logic              mode_master,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              slave_en,
  output logic              master_en,
  output logic [ADDR_W-1:0] own_addr
);
  logic              slv_d, mst_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    slv_d  = slave_en;
    mst_d  = master_en;
    addr_d = own_addr;
    if (mode_wr) begin
      slv_d = mode_slave;
      mst_d = mode_master & ~mode_slave;
    end
    if (addr_wr) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_en  <= 1'b0;
      master_en <= 1'b0;
      own_addr  <= '0;
    end else begin
      slave_en  <= slv_d;
      master_en <= mst_d;
      own_addr  <= addr_d;
    end
  end

  // R2: target request always overrides controller request
  p_slave_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_slave) |=> (slave_en && !master_en));
endmodule

// File: rtl/i2c_resp_fsm.sv
module i2c_resp_fsm
  import i2c_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              tx_go,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rx_pending,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [STAT_W-1:0] ev,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  resp_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, txb_q, txb_d, rxb_d;
  logic              rd_q, rd_d, act_q, act_d, txf_q, txf_d;
  logic [BYTE_W-1:0] shifted_in;

  assign shifted_in = {sh_q[BYTE_W-2:0], sda_s};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    txb_d = txb_q;
    rxb_d = rx_byte;
    rd_d  = rd_q;
    act_d = act_q;
    txf_d = txf_q;
    ev    = '0;
    if (!slave_en) begin
      st_d  = S_IDLE;
      act_d = 1'b0;
      txf_d = 1'b0;
    end else if (stop_det) begin
      ev[ST_STOP] = act_q;
      st_d  = S_IDLE;
      act_d = 1'b0;
      txf_d = 1'b0;
    end else if (start_det) begin
      st_d  = S_ADDR;
      cnt_d = '0;
      act_d = 1'b0;
      txf_d = 1'b0;
    end else begin
      if (tx_go) begin
        txf_d = 1'b1;
        txb_d = tx_data;
      end
      case (st_q)
        S_ADDR: if (scl_rise) begin
          sh_d  = shifted_in;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            if (sh_q[ADDR_W-1:0] == own_addr) begin
              ev[ST_MATCH]  = 1'b1;
              ev[ST_RXDONE] = 1'b1;
              rxb_d = shifted_in;
              rd_d  = sda_s;
              act_d = 1'b1;
              st_d  = S_ACK_PEND;
            end else begin
              st_d = S_IGNORE;
            end
          end
        end
        S_ACK_PEND: if (scl_fall) st_d = S_ACK_DRV;
        S_ACK_DRV: if (scl_fall) begin
          cnt_d = '0;
          st_d  = rd_q ? S_RD_WAIT : S_WR_BIT;
        end
        S_WR_BIT: if (scl_rise) begin
          sh_d  = shifted_in;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            ev[ST_RXDONE] = 1'b1;
            rxb_d = shifted_in;
            st_d  = S_ACK_PEND;
          end
        end
        S_RD_WAIT: if (txf_q) begin
          sh_d  = txb_q;
          txf_d = 1'b0;
          cnt_d = '0;
          st_d  = S_RD_SETUP;
        end
        S_RD_SETUP: st_d = S_RD_BIT;
        S_RD_BIT: if (scl_fall) begin
          sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) st_d = S_RD_ACK;
        end
        S_RD_ACK: if (scl_rise) begin
          if (sda_s) begin
            ev[ST_TXNAK] = 1'b1;
            st_d = S_IGNORE;
          end else begin
            ev[ST_TXACK] = 1'b1;
            st_d = S_RD_ACKED;
          end
        end
        S_RD_ACKED: if (scl_fall) st_d = S_RD_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      txb_q   <= '0;
      rx_byte <= '0;
      rd_q    <= 1'b0;
      act_q   <= 1'b0;
      txf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      txb_q   <= txb_d;
      rx_byte <= rxb_d;
      rd_q    <= rd_d;
      act_q   <= act_d;
      txf_q   <= txf_d;
    end
  end

  assign scl_oe = ((st_q == S_ACK_DRV) && rx_pending) ||
                  (st_q == S_RD_WAIT) || (st_q == S_RD_SETUP);
  assign sda_oe = (st_q == S_ACK_DRV) ||
                  (((st_q == S_RD_SETUP) || (st_q == S_RD_BIT)) && !sh_q[BYTE_W-1]);

  // R6: stretching only extends a low phase the controller began
  p_stretch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_s);
  // R7: SDA pull-down only begins while SCL is low
  p_sda_change_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2c_addr_responder.sv
module i2c_addr_responder
  import i2c_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              mode_wr,
  input  logic              mode_slave,
  input  logic              mode_master,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              slave_en,
  output logic              master_en,
  input  logic              tx_go,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic [STAT_W-1:0] irq_clr,
  output logic [STAT_W-1:0] irq_stat,
  output logic [BYTE_W-1:0] rx_data
);
  logic [1:0]        rst_pipe_q;
  logic              rst_ni;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;
  logic [STAT_W-1:0] ev, stat_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_resp_mode u_mode (
    .clk(clk), .rst_n(rst_ni), .mode_wr(mode_wr), .mode_slave(mode_slave),
    .mode_master(mode_master), .addr_wr(addr_wr), .addr_in(addr_in),
    .slave_en(slave_en), .master_en(master_en), .own_addr(own_addr)
  );

  i2c_resp_fsm u_fsm (
    .clk(clk), .rst_n(rst_ni), .slave_en(slave_en), .own_addr(own_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tx_go(tx_go), .tx_data(tx_data),
    .rx_pending(irq_stat[ST_RXDONE]), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev(ev), .rx_byte(rx_data)
  );

  // sticky status, new events win over clear
  assign stat_d = ev | (irq_stat & ~irq_clr);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) irq_stat <= '0;
    else         irq_stat <= stat_d;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat_chk
    // R12: a set bit survives until its clear bit is written
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_ni)
      (irq_stat[i] && !irq_clr[i]) |=> irq_stat[i]);
  end

  // R3: a match is always reported together with the address byte
  p_match_rx_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq_stat[ST_MATCH]) |-> irq_stat[ST_RXDONE]);
  // R11: a disabled target releases both lines
  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !slave_en |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_addr_responder.sv
`timescale 1ns/1ps
module tb_i2c_addr_responder;
  localparam int Q = 5;
  localparam int STRETCH_MAX = 4000;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic mode_wr = 0, mode_slave = 0, mode_master = 0, addr_wr = 0;
  logic [6:0] addr_in = '0;
  logic slave_en, master_en;
  logic tx_go = 0;
  logic [7:0] tx_data = '0;
  logic [4:0] agent_clr = '0, tb_clr = '0, irq_clr, irq_stat;
  logic [7:0] rx_data;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;
  assign irq_clr  = agent_clr | tb_clr;

  i2c_addr_responder dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .mode_wr(mode_wr), .mode_slave(mode_slave),
    .mode_master(mode_master), .addr_wr(addr_wr), .addr_in(addr_in),
    .slave_en(slave_en), .master_en(master_en), .tx_go(tx_go), .tx_data(tx_data),
    .irq_clr(irq_clr), .irq_stat(irq_stat), .rx_data(rx_data)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [6:0] own;

  // software agent state
  bit agent_on = 0;
  bit expect_addr = 0;
  logic [7:0] rx_log [16];
  int rx_n = 0;
  logic [7:0] tx_q [16];
  int tx_idx = 0, tx_n = 0, ack_n = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx();
    if (tx_idx < tx_n) begin
      tx_data = tx_q[tx_idx];
      tx_idx++;
      tx_go = 1'b1;
      @(negedge clk);
      tx_go = 1'b0;
    end
  endtask

  initial begin : agent
    bit is_addr;
    forever begin
      @(negedge clk);
      if (agent_on && irq_stat[2]) begin
        rx_log[rx_n] = rx_data;
        rx_n++;
        is_addr = expect_addr;
        expect_addr = 0;
        cyc($urandom_range(2, 30));
        agent_clr = 5'b00100;
        @(negedge clk);
        agent_clr = '0;
        if (is_addr && rx_log[rx_n-1][0]) push_tx();
      end else if (agent_on && irq_stat[0]) begin
        ack_n++;
        cyc($urandom_range(2, 30));
        agent_clr = 5'b00001;
        @(negedge clk);
        agent_clr = '0;
        push_tx();
      end
    end
  end

  task automatic wait_scl_high();
    int g = 0;
    while (scl_line !== 1'b1 && g < STRETCH_MAX) begin
      @(negedge clk);
      g++;
    end
    if (g >= STRETCH_MAX) chk("R6", "clock stretch released", 32'(scl_line), 32'd1);
  endtask

  task automatic m_bit(input logic b, output logic s);
    cyc(Q); m_sda = b;
    cyc(Q); m_scl = 1'b1;
    wait_scl_high();
    cyc(Q); s = sda_line;
    cyc(Q); m_scl = 1'b0;
  endtask

  task automatic m_start();
    cyc(Q); m_sda = 1'b1;
    cyc(Q); m_scl = 1'b1;
    wait_scl_high();
    cyc(Q); m_sda = 1'b0;
    cyc(2*Q); m_scl = 1'b0;
  endtask

  task automatic m_stop();
    cyc(Q); m_sda = 1'b0;
    cyc(Q); m_scl = 1'b1;
    wait_scl_high();
    cyc(Q); m_sda = 1'b1;
    cyc(2*Q);
  endtask

  task automatic m_write_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic m_read_byte(input bit last, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      d[i] = s;
    end
    m_bit(last, s);
  endtask

  task automatic clear_all();
    tb_clr = 5'h1f;
    @(negedge clk);
    tb_clr = '0;
    @(negedge clk);
  endtask

  task automatic write_mode(input logic s, input logic m);
    mode_slave = s; mode_master = m; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    @(negedge clk);
  endtask

  // expected ack on the address byte
  function automatic bit exp_hit(input logic [6:0] a, input bit en);
    return en && (a == own);
  endfunction

  task automatic do_xfer(input logic [6:0] a, input bit rd, input int n);
    bit acked, hit;
    logic [7:0] wr_q [16];
    logic [7:0] d;
    hit = exp_hit(a, slave_en);
    clear_all();
    rx_n = 0; tx_idx = 0; ack_n = 0; expect_addr = 1;
    tx_n = rd ? n : 0;
    for (int i = 0; i < n; i++) begin
      wr_q[i] = 8'($urandom);
      tx_q[i] = 8'($urandom);
    end
    m_start();
    m_write_byte({a, rd}, acked);
    chk(hit ? "R3" : "R4", "address ack", 32'(acked), 32'(hit));
    if (!acked) begin
      m_stop();
      cyc(10);
      chk("R4", "status after miss", 32'(irq_stat), 32'h0);
      chk("R4", "rx count after miss", 32'(rx_n), 32'd0);
      return;
    end
    if (!rd) begin
      for (int i = 0; i < n; i++) begin
        m_write_byte(wr_q[i], acked);
        chk("R5", "data ack", 32'(acked), 32'd1);
      end
      m_stop();
      cyc(10);
      chk("R5", "rx count", 32'(rx_n), 32'(n + 1));
      chk("R3", "address byte", 32'(rx_log[0]), 32'({a, 1'b0}));
      for (int i = 0; i < n; i++) chk("R5", "data byte", 32'(rx_log[i+1]), 32'(wr_q[i]));
    end else begin
      for (int i = 0; i < n; i++) begin
        m_read_byte(i == n - 1, d);
        chk("R7", "read byte", 32'(d), 32'(tx_q[i]));
      end
      m_stop();
      cyc(10);
      chk("R3", "address byte read", 32'(rx_log[0]), 32'({a, 1'b1}));
      chk("R8", "ack count", 32'(ack_n), 32'(n - 1));
      chk("R8", "nak bit", 32'(irq_stat[1]), 32'd1);
    end
    chk("R3", "match bit", 32'(irq_stat[4]), 32'd1);
    chk("R9", "stop bit", 32'(irq_stat[3]), 32'd1);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin : main
    int seed;
    bit acked;
    logic s;
    logic [6:0] other;
    logic [7:0] byte0;
    seed = $urandom(32'h5eed);
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1", "irq_stat", 32'(irq_stat), 32'h0);
    chk("R1", "scl_oe", 32'(scl_oe), 32'd0);
    chk("R1", "sda_oe", 32'(sda_oe), 32'd0);
    chk("R1", "enables", 32'({slave_en, master_en}), 32'd0);

    own = 7'($urandom_range(8, 119));
    addr_in = own; addr_wr = 1'b1; @(negedge clk); addr_wr = 1'b0; @(negedge clk);

    // R2 mode exclusivity
    write_mode(1'b1, 1'b1);
    chk("R2", "both requested", 32'({slave_en, master_en}), 32'b10);
    write_mode(1'b0, 1'b1);
    chk("R2", "controller only", 32'({slave_en, master_en}), 32'b01);

    // R11 disabled target ignores its own address
    agent_on = 1;
    do_xfer(own, 1'b0, 2);
    write_mode(1'b1, 1'b0);
    chk("R2", "target only", 32'({slave_en, master_en}), 32'b10);

    // R6 directed stretch with software held back
    agent_on = 0;
    clear_all();
    m_start();
    for (int i = 7; i >= 1; i--) m_bit(own[i-1], s);
    m_bit(1'b0, s);
    cyc(Q); m_sda = 1'b1;
    cyc(Q); m_scl = 1'b1;
    cyc(100);
    chk("R6", "scl held after address", 32'(scl_line), 32'd0);
    chk("R3", "ack driven", 32'(sda_line), 32'd0);
    chk("R3", "rx_data address", 32'(rx_data), 32'({own, 1'b0}));
    chk("R3", "match+rxdone", 32'({irq_stat[4], irq_stat[2]}), 32'b11);
    tb_clr = 5'b00100; @(negedge clk); tb_clr = '0;
    wait_scl_high();
    chk("R6", "scl released after clear", 32'(scl_line), 32'd1);
    cyc(Q); m_scl = 1'b0;
    byte0 = 8'hA5;
    for (int i = 7; i >= 0; i--) m_bit(byte0[i], s);
    cyc(Q); m_sda = 1'b1;
    cyc(Q); m_scl = 1'b1;
    cyc(150);
    chk("R6", "scl held after data", 32'(scl_line), 32'd0);
    chk("R5", "rx_data data", 32'(rx_data), 32'hA5);
    chk("R5", "auto ack", 32'(sda_line), 32'd0);
    tb_clr = 5'b00100; @(negedge clk); tb_clr = '0;
    wait_scl_high();
    cyc(Q); m_scl = 1'b0;
    m_stop();
    cyc(10);
    chk("R9", "stop after directed", 32'(irq_stat[3]), 32'd1);

    // R12 sticky and write-one-to-clear
    cyc(20);
    chk("R12", "bits held", 32'({irq_stat[4], irq_stat[3]}), 32'b11);
    tb_clr = 5'b10000; @(negedge clk); tb_clr = '0;
    chk("R12", "match cleared, stop kept", 32'({irq_stat[4], irq_stat[3]}), 32'b01);

    // R10 repeated start: miss, then hit, in one session
    agent_on = 1;
    clear_all();
    other = own ^ 7'h15;
    rx_n = 0; expect_addr = 1; tx_n = 0;
    m_start();
    m_write_byte({other, 1'b0}, acked);
    chk("R10", "first address missed", 32'(acked), 32'd0);
    m_start();
    m_write_byte({own, 1'b0}, acked);
    chk("R10", "readdressed ack", 32'(acked), 32'd1);
    m_write_byte(8'h3C, acked);
    m_stop();
    cyc(10);
    chk("R10", "byte after restart", 32'(rx_log[1]), 32'h3C);
    chk("R10", "stop bit", 32'(irq_stat[3]), 32'd1);

    // constrained random transactions
    for (int t = 0; t < 14; t++) begin
      bit rd, hit;
      int n;
      logic [6:0] a;
      rd  = 1'($urandom_range(0, 1));
      n   = $urandom_range(1, 4);
      hit = ($urandom_range(0, 3) != 0);
      a   = hit ? own : 7'(own ^ (7'h01 << $urandom_range(0, 6)));
      do_xfer(a, rd, n);
      if (t == 7) begin
        own = 7'($urandom_range(8, 119));
        addr_in = own; addr_wr = 1'b1; @(negedge clk); addr_wr = 1'b0; @(negedge clk);
      end
    end
    // boundary: single-byte read ends on NAK immediately
    do_xfer(own, 1'b1, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule